// File: doc/BRIEF.md
# Infrared SIR Pulse Encoder

This block turns the transmit line of a UART into the short light pulses used by serial infrared links. A zero bit on the line becomes one narrow active-high pulse on the LED drive output. A one bit leaves the output low. The output idles low, and any open-drain inversion lies outside the block.

All logic runs on one system clock. A single-cycle enable marks the ticks of a timebase at sixteen times the serial bit rate. A 4-bit phase counter locks onto each falling edge of the line that arrives while the encoder is idle. The pulse rises on the seventh tick after that lock point, and the line is sampled at the same moment, in the middle of the bit.

A mode input selects the pulse width:
- Mode 0 gives a width of three ticks, which is 3/16 of a bit.
- Mode 1 gives a fixed width counted in system clocks, derived from the clock frequency and a target of 1.6 µs. Mode 1 is also what a pad pull-up yields when the pin is left open.

Top module: `sir_pulse_encoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, `ir_pulse` is 0 after that edge. A reset taken in the middle of a pulse ends the pulse, and the encoder returns to idle. After release with the line high, no pulse appears.
- R2: Exactly one pulse is produced for each 0 bit, and none for a 1 bit.
- R3: The line passes through a two-flop synchronizer and a one-cycle edge register. On the first tick strictly after the edge register sees the falling edge, the phase counter has already restarted. The pulse rises at the edge of the seventh such tick.
- R4: With `fixed_width_sel` = 0 at pulse start, the pulse lasts exactly 3 ticks. It falls at the edge of the third tick after it rose.
- R5: With `fixed_width_sel` = 1 at pulse start, the pulse lasts `FIXED_CYCLES` system clocks, where `FIXED_CYCLES` = floor(`REF_HZ` × `PULSE_NS` / 1e9). With the defaults this is 29 clocks at 18.432 MHz, about 1.57 µs, which lies inside 1.41–2.23 µs.
- R6: During a run of consecutive 0 bits the encoder stays locked. Successive pulses rise exactly 16 ticks apart.
- R7: The mode value (1 = fixed width, the open-pin default) is captured when a pulse starts. Changing it during the pulse does not change that pulse's width.
- R8: If the phase restart caused by a falling edge lands in the same cycle as a tick, the restart wins and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the reference for the fixed width |
| rst_n | input | 1 | Synchronous active-low reset; must be asserted at startup |
| tick16_en | input | 1 | One-cycle enable at 16× the bit rate |
| uart_txd | input | 1 | UART transmit line, idle high |
| fixed_width_sel | input | 1 | 1 = fixed-width pulse (open-pin default), 0 = 3/16-bit pulse |
| ir_pulse | output | 1 | Registered LED drive, active high |

## Verification
Two things can fall in the same cycle: the phase restart triggered by a falling edge, and a 16× tick. The bench provokes this by placing a frame's bit boundary two clocks before a tick, so that the synchronizer and edge-register delay lands the restart exactly on the tick. It judges the outcome by requiring the pulse to rise seven full ticks after that tick, not six. Other frames use random tick offsets. The mode is flipped in the middle of a pulse to confirm that the captured width holds.

// File: rtl/sir_enc_pkg.sv
package sir_enc_pkg;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_state_e;

  // Whole reference-clock cycles that fit in the requested time.
  function automatic int ns_to_cycles(input longint hz, input longint ns);
    return int'((hz * ns) / 64'd1_000_000_000);
  endfunction

endpackage

// File: rtl/sir_in_sync.sv
module sir_in_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= stg[i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/sir_bit_phase.sv
module sir_bit_phase
  import sir_enc_pkg::*;
#(
  parameter int PHASE_W    = 4,
  parameter int FIRE_PHASE = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_en,
  input  logic               line,
  output logic               fire,
  output logic               running,
  output logic [PHASE_W-1:0] phase
);

  localparam logic [PHASE_W-1:0] PRE_FIRE = PHASE_W'(FIRE_PHASE - 1);

  phase_state_e      st_q;
  logic [PHASE_W-1:0] ph_q;
  logic              line_d;
  logic              fall;
  logic              at_pre_fire;

  assign fall        = line_d & ~line;
  assign at_pre_fire = (st_q == PH_RUN) && tick_en && (ph_q == PRE_FIRE);
  assign fire        = at_pre_fire && !line;
  assign running     = (st_q == PH_RUN);
  assign phase       = ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n) line_d <= 1'b1;
    else        line_d <= line;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= PH_IDLE;
      ph_q <= '0;
    end else begin
      case (st_q)
        PH_IDLE: begin
          if (fall) begin
            st_q <= PH_RUN;
            ph_q <= '0;
          end
        end
        PH_RUN: begin
          if (tick_en) begin
            ph_q <= ph_q + 1'b1;
            if (at_pre_fire && line) st_q <= PH_IDLE;
          end
        end
        default: st_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sir_pulse_width.sv
module sir_pulse_width #(
  parameter int FIXED_CYCLES = 29,
  parameter int SHORT_TICKS  = 3,
  parameter int CNT_W        = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             start,
  input  logic             fixed_sel,
  output logic             pulse,
  output logic             fixed_q,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] FIX_LOAD   = CNT_W'(FIXED_CYCLES - 1);
  localparam logic [CNT_W-1:0] SHORT_LOAD = CNT_W'(SHORT_TICKS - 1);

  logic             pulse_q;
  logic [CNT_W-1:0] cnt_q;
  logic             step;

  // Fixed width counts every clock; short width counts ticks.
  assign step = fixed_q ? 1'b1 : tick_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      fixed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (start) begin
      pulse_q <= 1'b1;
      fixed_q <= fixed_sel;
      cnt_q   <= fixed_sel ? FIX_LOAD : SHORT_LOAD;
    end else if (pulse_q && step) begin
      if (cnt_q == '0) pulse_q <= 1'b0;
      else             cnt_q   <= cnt_q - 1'b1;
    end
  end

  assign pulse = pulse_q;
  assign cnt   = cnt_q;

endmodule

// File: rtl/sir_pulse_encoder.sv
module sir_pulse_encoder
  import sir_enc_pkg::*;
#(
  parameter longint REF_HZ      = 18_432_000,
  parameter longint PULSE_NS    = 1600,
  parameter int     PHASE_W     = 4,
  parameter int     FIRE_PHASE  = 7,
  parameter int     SHORT_TICKS = 3,
  parameter int     SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick16_en,
  input  logic uart_txd,
  input  logic fixed_width_sel,
  output logic ir_pulse
);

  localparam int FIXED_CYCLES = ns_to_cycles(REF_HZ, PULSE_NS);
  localparam int CNT_MAX      = (FIXED_CYCLES > SHORT_TICKS) ? FIXED_CYCLES - 1 : SHORT_TICKS - 1;
  localparam int CNT_W        = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX + 1);

  logic [1:0]         sync_q;
  logic               fire_w;
  logic               run_w;
  logic [PHASE_W-1:0] phase_w;
  logic               fixed_w;
  logic [CNT_W-1:0]   cnt_w;

  // bit 1: transmit line, bit 0: width mode (both reset high)
  sir_in_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({uart_txd, fixed_width_sel}),
    .q     (sync_q)
  );

  sir_bit_phase #(.PHASE_W(PHASE_W), .FIRE_PHASE(FIRE_PHASE)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick16_en),
    .line    (sync_q[1]),
    .fire    (fire_w),
    .running (run_w),
    .phase   (phase_w)
  );

  sir_pulse_width #(
    .FIXED_CYCLES (FIXED_CYCLES),
    .SHORT_TICKS  (SHORT_TICKS),
    .CNT_W        (CNT_W)
  ) u_width (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick16_en),
    .start     (fire_w),
    .fixed_sel (sync_q[0]),
    .pulse     (ir_pulse),
    .fixed_q   (fixed_w),
    .cnt       (cnt_w)
  );

endmodule

// File: rtl/sir_pulse_encoder_chk.sv
module sir_pulse_encoder_chk #(
  parameter int PHASE_W    = 4,
  parameter int FIRE_PHASE = 7,
  parameter int CNT_W      = 5,
  parameter int CNT_MAX    = 28
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick16_en,
  input logic               ir_pulse,
  input logic               running,
  input logic               fixed_q,
  input logic [PHASE_W-1:0] phase,
  input logic [CNT_W-1:0]   cnt
);

  // R1
  reset_clears_chk: assert property (@(posedge clk) !rst_n |=> !ir_pulse);

  // R3
  rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ir_pulse) |-> $past(tick16_en));

  // R6
  rise_at_fire_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ir_pulse) |-> (phase == PHASE_W'(FIRE_PHASE)));

  // R2
  pulse_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ir_pulse |-> running);

  // R4
  short_ends_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ir_pulse) && !fixed_q) |-> $past(tick16_en));

  // R5
  width_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(CNT_MAX));

  // R7
  mode_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_pulse && $past(ir_pulse)) |-> $stable(fixed_q));

endmodule

bind sir_pulse_encoder sir_pulse_encoder_chk #(
  .PHASE_W    (PHASE_W),
  .FIRE_PHASE (FIRE_PHASE),
  .CNT_W      (CNT_W),
  .CNT_MAX    (CNT_MAX)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick16_en (tick16_en),
  .ir_pulse  (ir_pulse),
  .running   (run_w),
  .fixed_q   (fixed_w),
  .phase     (phase_w),
  .cnt       (cnt_w)
);

// File: tb/sim_sir_pulse_encoder.sv
module sim_sir_pulse_encoder;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 10;            // system clocks per 16x tick
  localparam int BIT_CLKS   = 16 * DIV;
  localparam int FIX_W      = 29;            // floor(18.432 MHz * 1600 ns)
  localparam int SHORT_W    = 3 * DIV;
  localparam int MAXP       = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick16_en = 1'b0;
  logic uart_txd = 1'b1;
  logic fixed_width_sel = 1'b1;
  logic ir_pulse;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;
  bit mon_en = 1'b1;
  logic prev_p = 1'b0;

  int    exp_start [MAXP];
  int    exp_w     [MAXP];
  string exp_tag_s [MAXP];
  string exp_tag_w [MAXP];
  int    got_start [MAXP];
  int    got_w     [MAXP];
  int    n_exp = 0;
  int    n_got = 0;
  int    cur_start = 0;
  logic  last_bit = 1'b1;

  sir_pulse_encoder #(.REF_HZ(18_432_000), .PULSE_NS(1600)) u0 (
    .clk             (clk),
    .rst_n           (rst_n),
    .tick16_en       (tick16_en),
    .uart_txd        (uart_txd),
    .fixed_width_sel (fixed_width_sel),
    .ir_pulse        (ir_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) tick16_en = ((cyc + 1) % DIV == 0);

  always @(negedge clk) begin
    if (mon_en && rst_n) begin
      if (ir_pulse && !prev_p) cur_start = cyc;
      if (!ir_pulse && prev_p && n_got < MAXP) begin
        got_start[n_got] = cur_start;
        got_w[n_got]     = cyc - cur_start;
        n_got++;
      end
    end
    prev_p = ir_pulse;
  end

  function automatic int first_tick_after(input int x);
    return (x / DIV + 1) * DIV;
  endfunction

  function automatic int expect_rise(input int b);
    return first_tick_after(b + 2) + 6 * DIV;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic note_pulse(input int b, input string stag, input string wtag);
    exp_start[n_exp] = expect_rise(b);
    exp_w[n_exp]     = fixed_width_sel ? FIX_W : SHORT_W;
    exp_tag_s[n_exp] = stag;
    exp_tag_w[n_exp] = wtag;
    n_exp++;
  endtask

  // Drives one bit at the next negedge; returns at the negedge before the next bit.
  task automatic drive_bit(input logic b, input string first_tag);
    int bstart;
    @(negedge clk);
    uart_txd = b;
    bstart = cyc + 1;
    if (!b) note_pulse(bstart, last_bit ? first_tag : "R6",
                       fixed_width_sel ? "R5" : "R4");
    last_bit = b;
    repeat (BIT_CLKS - 1) @(negedge clk);
  endtask

  task automatic compare_all();
    check(n_got == n_exp, "R2", n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++) begin
      check(got_start[i] == exp_start[i], exp_tag_s[i], got_start[i], exp_start[i]);
      check(got_w[i] == exp_w[i], exp_tag_w[i], got_w[i], exp_w[i]);
    end
    n_exp = 0;
    n_got = 0;
  endtask

  task automatic send_frame(input logic [7:0] data, input string ftag);
    drive_bit(1'b0, ftag);
    for (int i = 0; i < 8; i++) drive_bit(data[i], ftag);
    drive_bit(1'b1, ftag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int bs, sp;
    void'($urandom(32'h51C0DE));
    repeat (5) @(negedge clk);
    // R1: output low under reset
    check(ir_pulse == 1'b0, "R1", ir_pulse, 0);
    rst_n = 1'b1;
    repeat (3 * BIT_CLKS) @(negedge clk);
    check(n_got == 0, "R1", n_got, 0);

    // R5: default fixed width lies in the accepted window
    check((FIX_W * 1_000_000_000.0 / 18_432_000.0) >= 1410.0 &&
          (FIX_W * 1_000_000_000.0 / 18_432_000.0) <= 2230.0, "R5", FIX_W, 29);

    // Directed: all zeros and all ones, both modes
    fixed_width_sel = 1'b0;
    repeat (2 * BIT_CLKS) @(negedge clk);
    send_frame(8'h00, "R3");
    send_frame(8'hFF, "R3");
    fixed_width_sel = 1'b1;
    repeat (2 * BIT_CLKS) @(negedge clk);
    send_frame(8'h00, "R3");
    send_frame(8'h55, "R3");
    repeat (BIT_CLKS) @(negedge clk);
    compare_all();

    // R8: restart lands on a tick (bit start two clocks before a tick)
    for (int m = 0; m < 2; m++) begin
      fixed_width_sel = logic'(m);
      repeat (2 * BIT_CLKS) @(negedge clk);
      while (((cyc + 1) % DIV) != DIV - 2) @(negedge clk);
      // drive_bit waits one negedge first, so step back one clock
      repeat (DIV - 1) @(negedge clk);
      send_frame(8'hA6, "R8");
      repeat (BIT_CLKS) @(negedge clk);
      compare_all();
    end

    // Random frames, random tick alignment and mode
    for (int f = 0; f < 24; f++) begin
      fixed_width_sel = logic'($urandom_range(0, 1));
      repeat (2 * BIT_CLKS + $urandom_range(0, DIV - 1)) @(negedge clk);
      send_frame(8'($urandom_range(0, 255)), "R3");
      if (f % 6 == 5) begin
        repeat (BIT_CLKS) @(negedge clk);
        compare_all();
      end
    end
    repeat (BIT_CLKS) @(negedge clk);
    compare_all();

    // R7: mode flipped during a fixed-width pulse
    fixed_width_sel = 1'b1;
    repeat (2 * BIT_CLKS) @(negedge clk);
    @(negedge clk);
    uart_txd = 1'b0;
    bs = cyc + 1;
    sp = expect_rise(bs);
    note_pulse(bs, "R3", "R7");
    while (cyc < sp + 5) @(negedge clk);
    fixed_width_sel = 1'b0;
    while (cyc < bs + BIT_CLKS - 2) @(negedge clk);
    last_bit = 1'b0;
    drive_bit(1'b1, "R3");
    repeat (BIT_CLKS) @(negedge clk);
    compare_all();

    // R1: reset in the middle of a pulse
    fixed_width_sel = 1'b0;
    repeat (2 * BIT_CLKS) @(negedge clk);
    @(negedge clk);
    uart_txd = 1'b0;
    bs = cyc + 1;
    sp = expect_rise(bs);
    while (cyc < sp + 4) @(negedge clk);
    mon_en = 1'b0;
    check(ir_pulse == 1'b1, "R3", ir_pulse, 1);
    rst_n = 1'b0;
    uart_txd = 1'b1;
    @(negedge clk);
    check(ir_pulse == 1'b0, "R1", ir_pulse, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    n_got = 0;
    n_exp = 0;
    mon_en = 1'b1;
    repeat (2 * BIT_CLKS) @(negedge clk);
    check(n_got == 0, "R1", n_got, 0);
    last_bit = 1'b1;
    send_frame(8'h3C, "R3");
    repeat (BIT_CLKS) @(negedge clk);
    compare_all();

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule